// File: doc/BRIEF.md
# Transport Stream Capture with Ping-Pong Buffering

This block takes a packetised MPEG transport stream from an external channel decoder and stores it in memory through a simple word-wide write port. The decoder delivers the stream with a valid strobe and a start-of-packet marker. A mode input picks the format: one byte per valid cycle, or one bit per valid cycle. Packet boundaries come only from the start-of-packet marker. The block never searches the data for a sync pattern.

The block aligns on the marker and collects 188-byte packets. It packs the bytes little-endian into 32-bit words and passes them through a small FIFO to an address generator. The generator fills one buffer with a chosen number of packets, pulses that buffer's done flag, and then moves to the other buffer's base address. Software takes no part in the switch. A packet that is cut short by an early marker is dropped and counted, and the next packet is written over the same slot. A write port that stalls until the FIFO overflows sets a sticky flag.

Top module: `ts_capture`

## Requirements
- R1: While reset is held and on the first cycle after it, `wr_valid` is 0, `buf_done` is 0, `err_count` is 0 and `overflow` is 0.
- R2: When `serial_mode` is 0, every cycle with `ts_valid` high supplies one byte on `ts_data[7:0]`, and `ts_sop` marks the first byte of a packet.
- R3: When `serial_mode` is 1, every cycle with `ts_valid` high supplies one bit on `ts_data[0]`. The bit that comes with `ts_sop` is the most significant bit of the first byte, and bits arrive most significant first.
- R4: Bytes are discarded if they arrive after `enable` rises and before the first start-of-packet. Bytes that follow the 188th byte of a packet and come before the next start-of-packet are also discarded. Discarded bytes cause no write.
- R5: A packet is 188 bytes and is written as 47 words at addresses that rise by 4. Byte k of a word occupies bits 8k+7:8k, and a word is written only once all 4 of its bytes are present.
- R6: A start-of-packet that arrives before the current packet has 188 bytes drops that packet and adds 1 to `err_count`, which saturates at its maximum. The next packet is then written starting at the address where the dropped packet started.
- R7: A buffer holds `pkts_per_buf` packets, and a value of 0 acts as 1. Once a buffer is full, the next packet starts at the other buffer's base. Buffers alternate A, B, A and so on, beginning with A at `base_a`.
- R8: `buf_done[0]` (buffer A) or `buf_done[1]` (buffer B) goes high for exactly one cycle. That cycle follows the accepted write of the last word of the last packet in the buffer, and the two bits are never high together.
- R9: `overflow` is set when the block tries to store a word while the FIFO is full. It then stays set until reset.
- R10: Taking `enable` low clears packet alignment, empties the FIFO and returns the write pointer to `base_a` with buffer A selected. `err_count` and `overflow` are kept.
- R11: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stream and system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Capture enable; low clears alignment, FIFO and pointer |
| serial_mode | input | 1 | 0 = byte-wide input, 1 = bit-serial on ts_data[0] |
| ts_valid | input | 1 | Qualifies ts_data and ts_sop |
| ts_sop | input | 1 | Start-of-packet marker |
| ts_data | input | 8 | Stream byte, or serial bit in bit 0 |
| base_a | input | ADDR_W | Base address of buffer A |
| base_b | input | ADDR_W | Base address of buffer B |
| pkts_per_buf | input | PKTS_W | Packets per buffer (0 acts as 1) |
| wr_valid | output | 1 | Write request |
| wr_ready | input | 1 | Write accepted when high with wr_valid |
| wr_addr | output | ADDR_W | Byte address of the word |
| wr_data | output | 32 | Packed word, little-endian |
| buf_done | output | 2 | One-cycle done pulse per buffer |
| err_count | output | ERR_W | Saturating count of short packets |
| overflow | output | 1 | Sticky FIFO overflow flag |

## Verification
The assertions assume that `wr_ready` comes from a well-behaved sink, so a request that is not yet accepted is never withdrawn from the block's side. They also assume that `enable` stays high while a write is stalled, and that `base_a`, `base_b` and `pkts_per_buf` change only while capture is idle. The stimulus follows these rules. It changes the mode and the buffer settings only between packets, once the FIFO has drained. It drops `enable` only after all expected writes have been accepted, or in the final overflow phase, when write checking is switched off. The throttled `wr_ready` pattern keeps the FIFO below its depth everywhere except in the phase built to overflow it.

// File: rtl/ts_cap_pkg.sv
// Shared constants and the FIFO entry type for the transport stream capture block.
package ts_cap_pkg;
    localparam int WORD_W         = 32;
    localparam int BYTES_PER_WORD = WORD_W / 8;
    localparam int LANE_W         = $clog2(BYTES_PER_WORD);

    // One FIFO slot: either a data word or a marker that rewinds the pointer.
    typedef struct packed {
        logic              abort;
        logic              last;
        logic [WORD_W-1:0] data;
    } fifo_ent_t;
endpackage

// File: rtl/ts_deser.sv
// Input front end. Turns the parallel or serial stream into a byte stream,
// one byte per output strobe, with a flag on the first byte of a packet.
// Assumes that the serial bit arrives on in_data[0] MSB first and that a
// start-of-packet marker restarts byte alignment.
module ts_deser (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       serial_mode,
    input  logic       in_valid,
    input  logic       in_sop,
    input  logic [7:0] in_data,
    output logic       byte_valid,
    output logic       byte_sop,
    output logic [7:0] byte_data
);
    logic [6:0] shreg;
    logic [2:0] bit_cnt;
    logic       pend_sop;
    logic [6:0] shreg_base;
    logic [2:0] cnt_base;
    logic       sop_base;

    // Pick the starting point for a serial bit: restart on a marker.
    always_comb begin
        shreg_base = in_sop ? 7'd0 : shreg;
        cnt_base   = in_sop ? 3'd0 : bit_cnt;
        sop_base   = in_sop | pend_sop;
    end

    // Build bytes from the input and flag the first one of each packet.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            shreg      <= '0;
            bit_cnt    <= '0;
            pend_sop   <= 1'b0;
            byte_valid <= 1'b0;
            byte_sop   <= 1'b0;
            byte_data  <= '0;
        end else begin
            byte_valid <= 1'b0;
            if (in_valid) begin
                if (!serial_mode) begin
                    byte_valid <= 1'b1;
                    byte_sop   <= in_sop;
                    byte_data  <= in_data;
                end else if (cnt_base == 3'd7) begin
                    byte_valid <= 1'b1;
                    byte_sop   <= sop_base;
                    byte_data  <= {shreg_base, in_data[0]};
                    bit_cnt    <= 3'd0;
                    pend_sop   <= 1'b0;
                end else begin
                    shreg      <= {shreg_base[5:0], in_data[0]};
                    bit_cnt    <= cnt_base + 3'd1;
                    pend_sop   <= sop_base;
                end
            end
        end
    end
endmodule

// File: rtl/ts_packer.sv
// Packet aligner and word packer. Counts bytes from each start-of-packet,
// packs them little-endian into words, and issues an abort entry when a
// marker cuts a packet short. Assumes at most one byte per cycle.
module ts_packer
    import ts_cap_pkg::*;
#(
    parameter int PKT_BYTES = 188,
    parameter int ERR_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             byte_valid,
    input  logic             byte_sop,
    input  logic [7:0]       byte_data,
    output logic             push,
    output fifo_ent_t        push_ent,
    output logic [ERR_W-1:0] err_count
);
    localparam int CNT_W = $clog2(PKT_BYTES + 1);

    logic [CNT_W-1:0]  byte_cnt;
    logic [LANE_W-1:0] lane;
    logic [WORD_W-9:0] part;
    logic              in_pkt;
    logic              abort_now;
    logic              pkt_end;

    assign abort_now = enable && byte_valid && byte_sop && in_pkt;
    assign pkt_end   = (byte_cnt == CNT_W'(PKT_BYTES - 1));

    // Track packet position and emit complete words or abort markers.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            byte_cnt <= '0;
            lane     <= '0;
            part     <= '0;
            in_pkt   <= 1'b0;
            push     <= 1'b0;
            push_ent <= '0;
        end else begin
            push <= 1'b0;
            if (byte_valid && byte_sop) begin
                if (in_pkt) begin
                    push     <= 1'b1;
                    push_ent <= '{abort: 1'b1, last: 1'b0, data: '0};
                end
                in_pkt    <= 1'b1;
                part[7:0] <= byte_data;
                lane      <= LANE_W'(1);
                byte_cnt  <= CNT_W'(1);
            end else if (byte_valid && in_pkt) begin
                if (lane == LANE_W'(BYTES_PER_WORD - 1)) begin
                    push     <= 1'b1;
                    push_ent <= '{abort: 1'b0, last: pkt_end, data: {byte_data, part}};
                end else begin
                    part[{lane, 3'b000} +: 8] <= byte_data;
                end
                lane     <= lane + LANE_W'(1);
                byte_cnt <= pkt_end ? '0 : byte_cnt + CNT_W'(1);
                if (pkt_end) in_pkt <= 1'b0;
            end
        end
    end

    // Count dropped packets, saturating, kept across enable changes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_count <= '0;
        end else if (abort_now && err_count != '1) begin
            err_count <= err_count + ERR_W'(1);
        end
    end

    // R6
    err_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_count != $past(err_count)) |-> $past(abort_now));
endmodule

// File: rtl/ts_fifo.sv
// Small synchronous FIFO between the packer and the write port. A push into
// a full FIFO is dropped; the caller records it. A flush empties it.
module ts_fifo
    import ts_cap_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      flush,
    input  logic      push,
    input  fifo_ent_t push_ent,
    input  logic      pop,
    output fifo_ent_t head,
    output logic      not_empty,
    output logic      full
);
    localparam int PTR_W = $clog2(DEPTH);

    fifo_ent_t        mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr;
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W:0]   count;
    logic             do_push;
    logic             do_pop;

    assign not_empty = (count != '0);
    assign full      = (count == (PTR_W+1)'(DEPTH));
    assign do_push   = push && !full;
    assign do_pop    = pop && not_empty;
    assign head      = mem[rd_ptr];

    // Store incoming entries.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_ent;
    end

    // Move the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
            if (do_pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
            count <= count + (PTR_W+1)'(do_push) - (PTR_W+1)'(do_pop);
        end
    end
endmodule

// File: rtl/ts_dma.sv
// Address generator for the write port. Writes data entries at a running
// address, rewinds to the packet start on an abort entry, and moves between
// the two buffers after the programmed number of packets. Assumes that the
// bases and the packet count are stable while capture runs.
module ts_dma
    import ts_cap_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PKTS_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  fifo_ent_t         head,
    input  logic              head_valid,
    input  logic [ADDR_W-1:0] base_a,
    input  logic [ADDR_W-1:0] base_b,
    input  logic [PKTS_W-1:0] pkts_per_buf,
    input  logic              wr_ready,
    output logic              pop,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic [1:0]        buf_done
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BYTES_PER_WORD);

    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] pkt_start;
    logic [PKTS_W-1:0] pkt_cnt;
    logic              buf_sel;
    logic              fire;
    logic              skip;
    logic              buf_full;

    assign skip     = head_valid && head.abort;
    assign wr_valid = head_valid && !head.abort;
    assign wr_data  = head.data;
    assign wr_addr  = cur_addr;
    assign fire     = wr_valid && wr_ready;
    assign pop      = fire || skip;
    assign buf_full = ({1'b0, pkt_cnt} + (PKTS_W+1)'(1)) >= {1'b0, pkts_per_buf};

    // Advance the address, rewind on abort, switch buffers when full.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            cur_addr  <= base_a;
            pkt_start <= base_a;
            pkt_cnt   <= '0;
            buf_sel   <= 1'b0;
            buf_done  <= '0;
        end else begin
            buf_done <= '0;
            if (skip) begin
                cur_addr <= pkt_start;
            end else if (fire && head.last && buf_full) begin
                buf_done[buf_sel] <= 1'b1;
                buf_sel   <= ~buf_sel;
                pkt_cnt   <= '0;
                cur_addr  <= buf_sel ? base_a : base_b;
                pkt_start <= buf_sel ? base_a : base_b;
            end else if (fire && head.last) begin
                pkt_cnt   <= pkt_cnt + PKTS_W'(1);
                cur_addr  <= cur_addr + STEP;
                pkt_start <= cur_addr + STEP;
            end else if (fire) begin
                cur_addr <= cur_addr + STEP;
            end
        end
    end

    // R11
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready && enable) |=>
            (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    // R8
    done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(buf_done));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_done != 2'b00) |=> (buf_done == 2'b00));
endmodule

// File: rtl/ts_capture.sv
// Top of the transport stream capture block. Chains the input front end,
// the packet packer, the word FIFO and the buffer address generator, and
// keeps the sticky overflow flag. Assumes one clock for stream and memory.
module ts_capture
    import ts_cap_pkg::*;
#(
    parameter int PKT_BYTES  = 188,
    parameter int ADDR_W     = 32,
    parameter int PKTS_W     = 8,
    parameter int ERR_W      = 8,
    parameter int FIFO_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              serial_mode,
    input  logic              ts_valid,
    input  logic              ts_sop,
    input  logic [7:0]        ts_data,
    input  logic [ADDR_W-1:0] base_a,
    input  logic [ADDR_W-1:0] base_b,
    input  logic [PKTS_W-1:0] pkts_per_buf,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic [1:0]        buf_done,
    output logic [ERR_W-1:0]  err_count,
    output logic              overflow
);
    logic       b_valid;
    logic       b_sop;
    logic [7:0] b_data;
    logic       push;
    fifo_ent_t  push_ent;
    fifo_ent_t  head;
    logic       head_valid;
    logic       full;
    logic       pop;

    ts_deser u_deser (
        .clk(clk), .rst_n(rst_n), .enable(enable), .serial_mode(serial_mode),
        .in_valid(ts_valid), .in_sop(ts_sop), .in_data(ts_data),
        .byte_valid(b_valid), .byte_sop(b_sop), .byte_data(b_data)
    );

    ts_packer #(.PKT_BYTES(PKT_BYTES), .ERR_W(ERR_W)) u_packer (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .byte_valid(b_valid), .byte_sop(b_sop), .byte_data(b_data),
        .push(push), .push_ent(push_ent), .err_count(err_count)
    );

    ts_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(!enable),
        .push(push), .push_ent(push_ent), .pop(pop),
        .head(head), .not_empty(head_valid), .full(full)
    );

    ts_dma #(.ADDR_W(ADDR_W), .PKTS_W(PKTS_W)) u_dma (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .head(head), .head_valid(head_valid),
        .base_a(base_a), .base_b(base_b), .pkts_per_buf(pkts_per_buf),
        .wr_ready(wr_ready), .pop(pop), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_data(wr_data), .buf_done(buf_done)
    );

    // Latch a lost push until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) overflow <= 1'b0;
        else if (push && full) overflow <= 1'b1;
    end

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R10
    flush_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !wr_valid);
endmodule

// File: tb/sim_ts_capture.sv
// Scoreboard bench: the stream driver feeds a reference model that queues
// expected writes, and a monitor compares each accepted write.
module sim_ts_capture;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        serial_mode = 1'b0;
    logic        ts_valid = 1'b0;
    logic        ts_sop = 1'b0;
    logic [7:0]  ts_data = 8'h00;
    logic [31:0] base_a = 32'h0000_1000;
    logic [31:0] base_b = 32'h0000_8000;
    logic [7:0]  pkts_per_buf = 8'd2;
    logic        wr_valid;
    logic        wr_ready = 1'b0;
    logic [31:0] wr_addr;
    logic [31:0] wr_data;
    logic [1:0]  buf_done;
    logic [7:0]  err_count;
    logic        overflow;

    always #2 clk = ~clk;

    ts_capture u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .serial_mode(serial_mode),
        .ts_valid(ts_valid), .ts_sop(ts_sop), .ts_data(ts_data),
        .base_a(base_a), .base_b(base_b), .pkts_per_buf(pkts_per_buf),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
        .wr_data(wr_data), .buf_done(buf_done), .err_count(err_count),
        .overflow(overflow)
    );

    int total = 0;
    int bad = 0;
    bit reported = 0;
    bit mon_on = 1;
    bit stall = 0;
    string cur_req = "R5";
    logic [63:0] expq[$];

    // Reference model state
    bit in_pkt = 0;
    int cnt_m = 0, lane_m = 0, pktn_m = 0, sel_m = 0, exp_err = 0;
    logic [31:0] addr_m, start_m, word_m;
    int exp_done[2] = '{0, 0};
    int got_done[2] = '{0, 0};

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic model_restart();
        in_pkt = 0; pktn_m = 0; sel_m = 0;
        addr_m = base_a; start_m = base_a;
    endtask

    task automatic model_byte(logic [7:0] b, bit sop);
        if (sop) begin
            if (in_pkt) begin addr_m = start_m; exp_err++; end
            in_pkt = 1; cnt_m = 0; lane_m = 0;
        end
        if (in_pkt) begin
            word_m[lane_m*8 +: 8] = b;
            cnt_m++; lane_m++;
            if (lane_m == 4) begin
                expq.push_back({addr_m, word_m});
                addr_m += 4; lane_m = 0;
            end
            if (cnt_m == 188) begin
                in_pkt = 0; pktn_m++;
                if (pktn_m >= ((pkts_per_buf == 0) ? 1 : int'(pkts_per_buf))) begin
                    exp_done[sel_m]++; sel_m ^= 1; pktn_m = 0;
                    addr_m = sel_m ? base_b : base_a;
                end
                start_m = addr_m;
            end
        end
    endtask

    task automatic drive_byte(logic [7:0] b, bit sop);
        if (!serial_mode) begin
            ts_valid = 1; ts_sop = sop; ts_data = b;
            @(posedge clk); #1;
        end else begin
            for (int i = 7; i >= 0; i--) begin
                ts_valid = 1; ts_sop = sop && (i == 7); ts_data = {7'b0, b[i]};
                @(posedge clk); #1;
            end
        end
        ts_valid = 0; ts_sop = 0;
        model_byte(b, sop);
    endtask

    task automatic send_packet(int n, logic [7:0] seed);
        for (int i = 0; i < n; i++) begin
            drive_byte(seed + 8'(i * 7), i == 0);
            if (i % 9 == 8) begin @(posedge clk); #1; end
        end
    endtask

    task automatic drain();
        while (expq.size() != 0) begin @(posedge clk); #1; end
        repeat (6) begin @(posedge clk); #1; end
    endtask

    // Write-port throttle: accept 3 of every 4 cycles unless stalled.
    initial begin
        int k = 0;
        forever begin
            @(posedge clk); #1;
            wr_ready = !stall && (k % 4 != 3);
            k++;
        end
    end

    // Monitor: compare every accepted write and count done pulses.
    always @(negedge clk) begin
        if (rst_n && mon_on) begin
            if (wr_valid && wr_ready) begin
                if (expq.size() == 0) begin
                    check(0, cur_req, "unexpected write addr", longint'(wr_addr), 0);
                end else begin
                    logic [63:0] e;
                    e = expq.pop_front();
                    check(wr_addr == e[63:32], cur_req, "addr", longint'(wr_addr), longint'(e[63:32]));
                    check(wr_data == e[31:0], cur_req, "data", longint'(wr_data), longint'(e[31:0]));
                end
            end
            if (buf_done[0]) got_done[0]++;
            if (buf_done[1]) got_done[1]++;
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        check(0, "R1", "watchdog expired", 0, 1);
        report();
    end

    initial begin
        model_restart();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(wr_valid == 0, "R1", "wr_valid in reset", wr_valid, 0);
        check(buf_done == 0, "R1", "buf_done in reset", buf_done, 0);
        check(err_count == 0, "R1", "err_count in reset", err_count, 0);
        check(overflow == 0, "R1", "overflow in reset", overflow, 0);
        @(posedge clk); #1;
        rst_n = 1; enable = 1;
        model_restart();
        @(negedge clk);
        check(wr_valid == 0 && overflow == 0, "R1", "state after reset", wr_valid, 0);
        @(posedge clk); #1;

        // R4: bytes before the first start-of-packet cause no write
        for (int i = 0; i < 9; i++) drive_byte(8'hA0 + 8'(i), 0);
        repeat (10) @(posedge clk);
        @(negedge clk);
        check(wr_valid == 0, "R4", "write before first sop", wr_valid, 0);
        @(posedge clk); #1;

        // R2 R5 R7: three parallel packets, buffer A fills, then B
        cur_req = "R2";
        send_packet(188, 8'h10);
        send_packet(188, 8'h55);
        send_packet(188, 8'h9C);
        drain();
        check(got_done[0] == 1, "R8", "done A count", got_done[0], 1);
        check(got_done[1] == 0, "R7", "done B count", got_done[1], 0);

        // R6: short packet, then a full one over the same slot; R4 trailing junk
        cur_req = "R6";
        send_packet(50, 8'h33);
        send_packet(188, 8'h71);
        for (int i = 0; i < 10; i++) drive_byte(8'hEE, 0);
        drain();
        check(err_count == 8'(exp_err), "R6", "err_count", err_count, exp_err);
        check(got_done[1] == 1, "R7", "done B after refill", got_done[1], 1);

        // R3: serial packets fill buffer A again
        cur_req = "R3";
        serial_mode = 1;
        send_packet(188, 8'h01);
        send_packet(188, 8'hC3);
        drain();
        check(got_done[0] == 2, "R3", "done A after serial", got_done[0], 2);

        // R7: zero packets per buffer acts as one
        cur_req = "R7";
        serial_mode = 0;
        pkts_per_buf = 8'd0;
        send_packet(188, 8'h42);
        drain();
        check(got_done[1] == 2, "R7", "done B with count 0", got_done[1], 2);
        check(got_done[0] == exp_done[0] && got_done[1] == exp_done[1], "R8",
              "done totals", got_done[0] + got_done[1], exp_done[0] + exp_done[1]);

        // R10: disable returns to buffer A base
        cur_req = "R10";
        pkts_per_buf = 8'd2;
        enable = 0;
        repeat (3) @(posedge clk); #1;
        enable = 1;
        model_restart();
        send_packet(188, 8'h27);
        drain();
        check(expq.size() == 0, "R10", "queue empty", expq.size(), 0);
        check(err_count == 8'(exp_err), "R10", "err_count kept", err_count, exp_err);

        // R9: stall the port until the FIFO overflows
        mon_on = 0;
        stall = 1;
        @(posedge clk); #1;
        check(overflow == 0, "R9", "overflow before stall", overflow, 0);
        send_packet(188, 8'h66);
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(overflow == 1, "R9", "overflow set", overflow, 1);
        check(wr_valid == 1, "R11", "request held under stall", wr_valid, 1);
        @(posedge clk); #1;
        enable = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(overflow == 1, "R9", "overflow sticky", overflow, 1);
        check(wr_valid == 0, "R10", "FIFO flushed", wr_valid, 0);
        report();
    end
endmodule